// File: doc/BRIEF.md
# Tri-state PWM gate-drive sequencer

This block turns a three-level PWM control signal into the two gate enables of a synchronous buck power stage: one for the high-side switch and one for the low-side switch. The analog pin is not modelled. It arrives as two comparator flags: one set above the upper threshold and one set below the lower threshold. When neither flag is set, the input is in the middle band. A brief stay in that band keeps the last valid level, which gives hysteresis. A stay that lasts a programmed number of clocks is taken as a floating driver, and both switches are parked off.

The block leaves that parked state only on a high input, and it comes out of reset already parked. The sequencer then puts a programmable gap, during which both outputs are low, between any release of one switch and the turn-on of the other. When the zero-current mode input is low, the sequencer runs in diode emulation. In that mode a zero-crossing flag seen while the low side conducts ends the low-side pulse for the rest of that PWM period. The enable input overrides all other inputs.

Top module: `pwm_gate_seq`

## Requirements
- R1: When pwm_hi is sampled high, the next state aims for gh=1 and gl=0. If pwm_hi and pwm_lo are both high, pwm_hi takes priority.
- R2: When only pwm_lo is sampled high, the next state aims for gl=1 and gh=0.
- R3: The input is mid-band when both flags are low. After HOLD_CYCLES consecutive mid-band samples, tristate_active is set and gh and gl are both 0 from the same edge. Any sample outside the band before that count completes restarts the count from zero.
- R4: Once tristate_active is set, only a sample with pwm_hi high clears it. Low samples and mid-band samples keep both outputs at 0.
- R5: After reset, tristate_active=1 and gh=gl=0. This state lasts until the first high sample, whether the input is low or mid-band in the meantime.
- R6: When zcd_en_n=0, a zero_cross sample while gl=1 drives gl to 0 at the next edge. gl then stays 0 until a rising PWM level, meaning a high sample that follows a low latched level.
- R7: When zcd_en_n=1, zero_cross has no effect: gl keeps following the low level.
- R8: A sample with enable=0 makes gh=gl=0 at the next edge. It does not change tristate_active.
- R9: gh and gl are never high at the same time. Between one output falling and either output rising, the outputs stay both low for at least max(dead_cycles,1) cycles. When the demand is steady, the gap is exactly that number of cycles. After a long idle time, an output turns on at the first edge.
- R10: A mid-band stay shorter than the hold-off keeps the last valid level, so the outputs continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_hi | input | 1 | Comparator flag: input above the upper threshold |
| pwm_lo | input | 1 | Comparator flag: input below the lower threshold |
| zcd_en_n | input | 1 | 0 selects diode emulation, 1 selects continuous conduction |
| zero_cross | input | 1 | Inductor current has reached zero |
| enable | input | 1 | 0 forces both gate enables low |
| dead_cycles | input | DT_W | Minimum number of both-low cycles between side changes |
| gh | output | 1 | High-side gate enable |
| gl | output | 1 | Low-side gate enable |
| tristate_active | output | 1 | Floating input detected; both switches parked |

## Verification
Three events can land on the same clock edge: the hold-off count completing, a zero-crossing cut, and the dead-time counter releasing the opposite side. Two cases are of particular interest. In the first, the PWM rises in the very edge in which a cut would have happened. In the second, a mid-band run ends exactly one sample before the hold-off count completes. The bench provokes both, first with directed runs of HOLD_CYCLES-1 and HOLD_CYCLES+2 mid samples, and then with long stretches of random level runs, zero-crossing pulses and dead-time values. A behavioural model judges every cycle for gh, gl and tristate_active.

// File: rtl/pwm_gate_seq.sv
module pwm_gate_seq #(
  parameter int HOLD_CYCLES = 38,
  parameter int DT_W        = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwm_hi,
  input  logic            pwm_lo,
  input  logic            zcd_en_n,
  input  logic            zero_cross,
  input  logic            enable,
  input  logic [DT_W-1:0] dead_cycles,
  output logic            gh,
  output logic            gl,
  output logic            tristate_active
);
  localparam int HC_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [HC_W-1:0] HOLD_LAST = HC_W'(HOLD_CYCLES - 1);
  localparam logic [DT_W-1:0] IDLE_MAX = {DT_W{1'b1}};

  logic            lvl_q, park_q, cut_q, gh_q, gl_q;
  logic [HC_W-1:0] hold_q;
  logic [DT_W-1:0] idle_q;

  logic mid, lvl_d, hold_done, park_d, rise, zc_hit, cut_d;
  logic run, want_h, want_l, gap_ok, gh_d, gl_d;

  assign mid       = !pwm_hi && !pwm_lo;
  assign lvl_d     = pwm_hi || (!pwm_lo && lvl_q);
  assign hold_done = mid && !park_q && (hold_q == HOLD_LAST);
  assign park_d    = !pwm_hi && (park_q || hold_done);
  assign rise      = pwm_hi && !lvl_q;
  assign zc_hit    = !zcd_en_n && zero_cross && gl_q;
  assign cut_d     = !rise && (cut_q || zc_hit);

  assign run    = enable && !park_d;
  assign want_h = run && lvl_d;
  assign want_l = run && !lvl_d && !cut_d;
  assign gap_ok = idle_q >= dead_cycles;
  assign gh_d   = want_h && (gh_q || (!gl_q && gap_ok));
  assign gl_d   = want_l && (gl_q || (!gh_q && gap_ok));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      park_q <= 1'b1;
      cut_q  <= 1'b0;
      gh_q   <= 1'b0;
      gl_q   <= 1'b0;
      hold_q <= '0;
      idle_q <= IDLE_MAX;
    end else begin
      lvl_q  <= lvl_d;
      park_q <= park_d;
      cut_q  <= cut_d;
      gh_q   <= gh_d;
      gl_q   <= gl_d;
      if (!mid || park_q || hold_done) hold_q <= '0;
      else                             hold_q <= hold_q + 1'b1;
      if (gh_q || gl_q)              idle_q <= DT_W'(1);
      else if (idle_q != IDLE_MAX)   idle_q <= idle_q + 1'b1;
    end
  end

  assign gh              = gh_q;
  assign gl              = gl_q;
  assign tristate_active = park_q;
endmodule

module pwm_gate_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic pwm_hi,
  input logic pwm_lo,
  input logic zcd_en_n,
  input logic zero_cross,
  input logic enable,
  input logic gh,
  input logic gl,
  input logic tristate_active
);
  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n) !(gh && gl));
  // R9
  gh_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(gh) |-> !$past(gl));
  // R9
  gl_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(gl) |-> !$past(gh));
  // R8
  enable_off_chk: assert property (@(posedge clk) disable iff (!rst_n) !enable |=> (!gh && !gl));
  // R3
  parked_low_chk: assert property (@(posedge clk) disable iff (!rst_n) tristate_active |-> (!gh && !gl));
  // R4
  exit_high_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(tristate_active) |-> $past(pwm_hi));
  // R6
  zc_cut_chk: assert property (@(posedge clk) disable iff (!rst_n) (!zcd_en_n && zero_cross && gl) |=> !gl);
  // R7
  ccm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zcd_en_n && gl && pwm_lo && !pwm_hi && enable) |=> gl);
endmodule

bind pwm_gate_seq pwm_gate_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
  .zcd_en_n(zcd_en_n), .zero_cross(zero_cross), .enable(enable),
  .gh(gh), .gl(gl), .tristate_active(tristate_active)
);

// File: tb/test_pwm_gate_seq.sv
`timescale 1ns/1ps
module test_pwm_gate_seq;
  localparam int HOLD = 38;
  localparam int DTW  = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwm_hi = 1'b0, pwm_lo = 1'b0, zcd_en_n = 1'b1, zero_cross = 1'b0, enable = 1'b1;
  logic [DTW-1:0] dead_cycles = 4'd3;
  logic gh, gl, tristate_active;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  string cur = "R5";

  always #2 clk = ~clk;

  pwm_gate_seq #(.HOLD_CYCLES(HOLD), .DT_W(DTW)) i_pwm_gate_seq (
    .clk(clk), .rst_n(rst_n), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
    .zcd_en_n(zcd_en_n), .zero_cross(zero_cross), .enable(enable),
    .dead_cycles(dead_cycles), .gh(gh), .gl(gl), .tristate_active(tristate_active)
  );

  // behavioural reference
  int m_level = 0, m_park = 1, m_cut = 0, m_gh = 0, m_gl = 0, m_run = 0, m_idle = 1000;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_level = 0; m_park = 1; m_cut = 0; m_gh = 0; m_gl = 0; m_run = 0; m_idle = 1000;
    end else begin
      int new_level, new_park, new_cut, goal_h, goal_l, nh, nl;
      int was_on;
      was_on = m_gh | m_gl;
      if (pwm_hi) new_level = 1; else if (pwm_lo) new_level = 0; else new_level = m_level;
      new_park = m_park;
      if (pwm_hi) begin new_park = 0; m_run = 0; end
      else if (!pwm_lo) begin
        if (!m_park) begin
          m_run = m_run + 1;
          if (m_run >= HOLD) begin new_park = 1; m_run = 0; end
        end else m_run = 0;
      end else m_run = 0;
      new_cut = m_cut;
      if (pwm_hi && m_level == 0) new_cut = 0;
      else if (!zcd_en_n && zero_cross && m_gl) new_cut = 1;
      goal_h = enable && !new_park && new_level == 1;
      goal_l = enable && !new_park && new_level == 0 && !new_cut;
      nh = goal_h && (m_gh || (!m_gl && m_idle >= dead_cycles));
      nl = goal_l && (m_gl || (!m_gh && m_idle >= dead_cycles));
      m_idle = was_on ? 1 : m_idle + 1;
      m_level = new_level; m_park = new_park; m_cut = new_cut; m_gh = nh; m_gl = nl;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (gh !== m_gh[0] || gl !== m_gl[0] || tristate_active !== m_park[0]) begin
        errors++;
        $display("FAIL %s cycle compare: gh/gl/tri actual %b%b%b expected %0d%0d%0d",
                 cur, gh, gl, tristate_active, m_gh, m_gl, m_park);
      end
    end
  end

  task automatic expect3(input string req, input logic eh, input logic el, input logic et);
    checks++;
    if (gh !== eh || gl !== el || tristate_active !== et) begin
      errors++;
      $display("FAIL %s directed: gh/gl/tri actual %b%b%b expected %b%b%b",
               req, gh, gl, tristate_active, eh, el, et);
    end
  endtask

  task automatic drive(input logic h, input logic l, input int n);
    pwm_hi = h; pwm_lo = l;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur = "R5";
    expect3("R5", 0, 0, 1);
    rst_n = 1'b1;
    drive(0, 1, 10); expect3("R5", 0, 0, 1);
    drive(0, 0, 5);  expect3("R5", 0, 0, 1);
    cur = "R1"; drive(1, 0, 2); expect3("R1", 1, 0, 0);
    cur = "R2"; drive(0, 1, 6); expect3("R2", 0, 1, 0);
    cur = "R1"; drive(1, 1, 6); expect3("R1", 1, 0, 0);
    cur = "R10"; drive(0, 0, HOLD - 1); expect3("R10", 1, 0, 0);
    cur = "R3"; drive(1, 0, 1); expect3("R3", 1, 0, 0);
    drive(0, 0, HOLD - 1); expect3("R3", 1, 0, 0);
    drive(0, 0, 3); expect3("R3", 0, 0, 1);
    cur = "R4"; drive(0, 1, 10); expect3("R4", 0, 0, 1);
    drive(1, 0, 3); expect3("R4", 1, 0, 0);
    cur = "R6"; zcd_en_n = 1'b0;
    drive(0, 1, 6); expect3("R6", 0, 1, 0);
    zero_cross = 1'b1; drive(0, 1, 1); zero_cross = 1'b0;
    expect3("R6", 0, 0, 0);
    drive(0, 1, 5); expect3("R6", 0, 0, 0);
    drive(1, 0, 5); drive(0, 1, 6); expect3("R6", 0, 1, 0);
    cur = "R7"; zcd_en_n = 1'b1; zero_cross = 1'b1;
    drive(0, 1, 6); expect3("R7", 0, 1, 0);
    zero_cross = 1'b0;
    cur = "R8"; drive(1, 0, 6);
    enable = 1'b0; drive(1, 0, 1); expect3("R8", 0, 0, 0);
    enable = 1'b1; drive(1, 0, 6); expect3("R8", 1, 0, 0);
    cur = "R9"; dead_cycles = 4'd0; drive(0, 1, 3); expect3("R9", 0, 1, 0);
    dead_cycles = 4'd5; drive(1, 0, 5); expect3("R9", 0, 0, 0);
    drive(1, 0, 1); expect3("R9", 1, 0, 0);
    cur = "R3";
    for (int k = 0; k < 400; k++) begin
      int sel, len;
      sel = $urandom_range(0, 5);
      len = (sel == 2) ? $urandom_range(HOLD - 2, HOLD + 1) : $urandom_range(1, 12);
      dead_cycles = 4'($urandom_range(0, 5));
      zcd_en_n    = ($urandom_range(0, 1) == 1);
      enable      = ($urandom_range(0, 9) != 0);
      zero_cross  = ($urandom_range(0, 3) == 0);
      case (sel)
        0, 1: drive(1, 0, len);
        2:    drive(0, 0, len);
        3:    drive(1, 1, len);
        default: drive(0, 1, len);
      endcase
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule